// File: doc/BRIEF.md
# Serial Save-Memory Command Responder

This block is the responding side of a small serial save memory that sits behind a cartridge SPI link. It works one byte at a time. Each transfer strobe delivers a byte from the master, and one cycle later the block presents the byte it shifts back. The first non-zero byte after chip select is taken becomes the latched command. Every byte that follows in the same select window is handled according to that command.

Three commands act on a one-bit write-enable latch held in a status register: set it, clear it, or read the status. The block also classifies the memory on the fly. The class starts undecided. If the first command latched while it is still undecided is the probe code, the class is fixed to a small EEPROM. While the class is undecided, any other command answers with a filler byte. The storage array, its addressing and its programming timing belong to other blocks.

The latched command is dropped when the master ends a transfer without holding chip select, or when it raises a separate command-reset input.

Top module: `save_spi_responder`

## Requirements
- R1: While no command is latched (latched value 0x00), a transfer byte becomes the latched command and the reply is 0x00. A received 0x00 leaves the block unlatched.
- R2: With 0x04 latched, every following transfer clears status bit 1 (write-enable, output `wel`) and replies 0x00.
- R3: With 0x06 latched, every following transfer sets status bit 1 and replies 0x00.
- R4: With 0x05 latched, every following transfer replies with the status register. Bit 1 is the write-enable latch and all other bits are 0.
- R5: `save_kind` uses 00 for none, 01 for small EEPROM, 10 for EEPROM and 11 for flash. After reset it is 00 and `kind_known` is 0. When 0x0B is latched as a command while `kind_known` is 0, the block sets `save_kind` to 01 and `kind_known` to 1. Both then stay fixed until reset.
- R6: With any other non-zero command latched, the reply is 0xFF while `kind_known` is 0 and 0x00 once it is 1.
- R7: A transfer with `cs_hold` low is processed normally, and the latched command is then cleared. The next byte is latched as a fresh command.
- R8: A pulse on `cmd_reset` clears the latched command. A transfer in the same cycle is first processed under the old command.
- R9: `tx_valid` is high in exactly the cycle after each transfer strobe. `tx_byte` changes only on those cycles.
- R10: Reset clears the status register, the latched command, `tx_valid` and `tx_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_strobe | input | 1 | One-cycle pulse: a byte has arrived from the master |
| rx_byte | input | 8 | Byte received from the master |
| cs_hold | input | 1 | Chip select stays asserted after this transfer |
| cmd_reset | input | 1 | Clears the latched command |
| tx_valid | output | 1 | Reply byte is fresh this cycle |
| tx_byte | output | 8 | Reply byte returned to the master |
| save_kind | output | 2 | Detected memory class |
| kind_known | output | 1 | Memory class has been fixed |
| wel | output | 1 | Write-enable latch (status bit 1) |

## Verification
A corrupted latched command appears at the ports on the next transfer. It shows up as a wrong reply byte (0xFF instead of 0x00, or status instead of zero), or as `wel` failing to move one cycle after a 0x04 or 0x06 data byte. A wrong write-enable bit is visible on `wel` at once, and in the reply to the next status read. A detection error shows on `save_kind` and `kind_known` one cycle after the probe byte, and in the filler-versus-zero reply of later unknown commands.

// File: rtl/svr_pkg.sv
package svr_pkg;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_PROBE = 8'h0B;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_WRDI  = 3'd1,
    OP_RDSR  = 3'd2,
    OP_WREN  = 3'd3,
    OP_OTHER = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    KIND_NONE      = 2'd0,
    KIND_EEP_SMALL = 2'd1,
    KIND_EEP       = 2'd2,
    KIND_FLASH     = 2'd3
  } kind_e;
endpackage

// File: rtl/svr_cmd_latch.sv
module svr_cmd_latch
  import svr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic [DW-1:0] rx,
  input  logic          hold,
  input  logic          clr,
  output logic [DW-1:0] cmd_q,
  output op_e           op
);
  // Decode of the latched command; zero means nothing is latched.
  always_comb begin
    if (cmd_q == '0)                 op = OP_IDLE;
    else if (cmd_q == DW'(CMD_WRDI)) op = OP_WRDI;
    else if (cmd_q == DW'(CMD_RDSR)) op = OP_RDSR;
    else if (cmd_q == DW'(CMD_WREN)) op = OP_WREN;
    else                             op = OP_OTHER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (clr) begin
      cmd_q <= '0;
    end else if (xfer) begin
      if (!hold)              cmd_q <= '0;
      else if (op == OP_IDLE) cmd_q <= rx;
    end
  end
endmodule

// File: rtl/svr_status.sv
module svr_status
  import svr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int WEL_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  op_e           op,
  output logic [DW-1:0] status_q,
  output logic          wel
);
  logic [DW-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (xfer && op == OP_WREN) status_d[WEL_BIT] = 1'b1;
    if (xfer && op == OP_WRDI) status_d[WEL_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  assign wel = status_q[WEL_BIT];
endmodule

// File: rtl/svr_kind_detect.sv
module svr_kind_detect
  import svr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  op_e           op,
  input  logic [DW-1:0] rx,
  output kind_e         kind,
  output logic          known
);
  logic probe_hit;
  assign probe_hit = xfer && (op == OP_IDLE) && !known && (rx == DW'(CMD_PROBE));

  always_ff @(posedge clk) begin
    if (rst) begin
      kind  <= KIND_NONE;
      known <= 1'b0;
    end else if (probe_hit) begin
      kind  <= KIND_EEP_SMALL;
      known <= 1'b1;
    end
  end
endmodule

// File: rtl/save_spi_responder.sv
module save_spi_responder
  import svr_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            WEL_BIT = 1,
  parameter logic [DW-1:0] FILL    = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_strobe,
  input  logic [DW-1:0] rx_byte,
  input  logic          cs_hold,
  input  logic          cmd_reset,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic [1:0]    save_kind,
  output logic          kind_known,
  output logic          wel
);
  logic [DW-1:0] cmd_q;
  logic [DW-1:0] status_q;
  op_e           op;
  kind_e         kind;
  logic [DW-1:0] reply_d;

  svr_cmd_latch #(.DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .xfer(xfer_strobe), .rx(rx_byte),
    .hold(cs_hold), .clr(cmd_reset), .cmd_q(cmd_q), .op(op)
  );

  svr_status #(.DW(DW), .WEL_BIT(WEL_BIT)) u_stat (
    .clk(clk), .rst(rst), .xfer(xfer_strobe), .op(op),
    .status_q(status_q), .wel(wel)
  );

  svr_kind_detect #(.DW(DW)) u_kind (
    .clk(clk), .rst(rst), .xfer(xfer_strobe), .op(op), .rx(rx_byte),
    .kind(kind), .known(kind_known)
  );

  // Reply selection from the command in force at the strobe.
  always_comb begin
    unique case (op)
      OP_RDSR:  reply_d = status_q;
      OP_OTHER: reply_d = kind_known ? '0 : FILL;
      default:  reply_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= xfer_strobe;
      if (xfer_strobe) tx_byte <= reply_d;
    end
  end

  assign save_kind = kind;
endmodule

// File: rtl/save_spi_responder_chk.sv
module save_spi_responder_chk
  import svr_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            WEL_BIT = 1,
  parameter logic [DW-1:0] FILL    = '1
) (
  input logic          clk,
  input logic          rst,
  input logic          xfer_strobe,
  input logic [DW-1:0] rx_byte,
  input logic          cs_hold,
  input logic          cmd_reset,
  input logic          tx_valid,
  input logic [DW-1:0] tx_byte,
  input logic [1:0]    save_kind,
  input logic          kind_known,
  input logic          wel,
  input logic [DW-1:0] cmd_q,
  input op_e           op
);
  a_r1_latch_cmd: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && op == OP_IDLE && cs_hold && !cmd_reset |=> cmd_q == $past(rx_byte));
  a_r1_zero_reply: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && op == OP_IDLE |=> tx_byte == '0);
  a_r2_wel_clear: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && op == OP_WRDI |=> !wel && tx_byte == '0);
  a_r3_wel_set: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && op == OP_WREN |=> wel && tx_byte == '0);
  a_r4_status_read: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && op == OP_RDSR |=> tx_byte[WEL_BIT] == $past(wel) && $countones(tx_byte) <= 1);
  a_r5_kind_sticky: assert property (@(posedge clk) disable iff (rst)
    kind_known |=> kind_known && $stable(save_kind));
  a_r6_fill_reply: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && op == OP_OTHER && !kind_known |=> tx_byte == FILL);
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && !cs_hold |=> cmd_q == '0);
  a_r8_cmd_reset: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> cmd_q == '0);
  a_r9_valid: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe |=> tx_valid);
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !xfer_strobe |=> !tx_valid && $stable(tx_byte));
  a_r10_reset: assert property (@(posedge clk)
    rst |=> !wel && cmd_q == '0 && !tx_valid && tx_byte == '0);
endmodule

bind save_spi_responder save_spi_responder_chk #(.DW(DW), .WEL_BIT(WEL_BIT), .FILL(FILL)) u_chk (
  .clk(clk), .rst(rst), .xfer_strobe(xfer_strobe), .rx_byte(rx_byte),
  .cs_hold(cs_hold), .cmd_reset(cmd_reset), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .save_kind(save_kind), .kind_known(kind_known), .wel(wel), .cmd_q(cmd_q), .op(op)
);

// File: tb/save_spi_responder_test.sv
module save_spi_responder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfer_strobe = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       cs_hold = 1'b0;
  logic       cmd_reset = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic [1:0] save_kind;
  logic       kind_known;
  logic       wel;

  int nchk = 0;
  int nerr = 0;

  // Reference state kept by the bench
  logic [7:0] mcmd;
  logic       mwel;
  logic       mknown;
  logic [7:0] last_tx;

  always #2 clk = ~clk;

  save_spi_responder uut (
    .clk(clk), .rst(rst), .xfer_strobe(xfer_strobe), .rx_byte(rx_byte),
    .cs_hold(cs_hold), .cmd_reset(cmd_reset), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .save_kind(save_kind), .kind_known(kind_known), .wel(wel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reply();
    case (mcmd)
      8'h00, 8'h04, 8'h06: return 8'h00;
      8'h05:               return {6'b0, mwel, 1'b0};
      default:             return mknown ? 8'h00 : 8'hFF;
    endcase
  endfunction

  function automatic void model_step(input logic [7:0] b, input logic h, input logic c);
    if (mcmd == 8'h00) begin
      if (b == 8'h0B && !mknown) mknown = 1'b1;
      mcmd = b;
    end else if (mcmd == 8'h04) mwel = 1'b0;
    else if (mcmd == 8'h06) mwel = 1'b1;
    if (!h || c) mcmd = 8'h00;
  endfunction

  task automatic send(input string req, input logic [7:0] b, input logic h, input logic c);
    logic [7:0] e;
    e = exp_reply();
    @(negedge clk);
    chk({req, "/R9 idle valid"}, {7'b0, tx_valid}, 8'h00);
    chk({req, "/R9 idle hold"}, tx_byte, last_tx);
    xfer_strobe = 1'b1; rx_byte = b; cs_hold = h; cmd_reset = c;
    @(negedge clk);
    xfer_strobe = 1'b0; cmd_reset = 1'b0;
    model_step(b, h, c);
    chk({req, "/R9 valid"}, {7'b0, tx_valid}, 8'h01);
    chk({req, " reply"}, tx_byte, e);
    chk({req, " wel"}, {7'b0, wel}, {7'b0, mwel});
    chk({req, "/R5 kind"}, {5'b0, kind_known, save_kind}, {5'b0, mknown, mknown ? 2'b01 : 2'b00});
    last_tx = tx_byte;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    mcmd = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mcmd = 8'h00; mwel = 1'b0; mknown = 1'b0; last_tx = 8'h00;
    chk("R10 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R10 tx_byte", tx_byte, 8'h00);
    chk("R10 wel", {7'b0, wel}, 8'h00);
    chk("R5 reset kind", {5'b0, kind_known, save_kind}, 8'h00);
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic       h;
    logic       c;
    int         r;
    void'($urandom(32'h5A17));
    mcmd = 8'h00; mwel = 1'b0; mknown = 1'b0; last_tx = 8'h00;
    do_reset();

    send("R1 zero stays idle", 8'h00, 1'b1, 1'b0);
    send("R1 latch", 8'h42, 1'b1, 1'b0);
    send("R6 filler", 8'h11, 1'b1, 1'b0);
    send("R7 last byte", 8'h22, 1'b0, 1'b0);
    send("R7 relatch WREN", 8'h06, 1'b1, 1'b0);
    send("R3 set", 8'h00, 1'b0, 1'b0);
    send("R4 latch", 8'h05, 1'b1, 1'b0);
    send("R4 read", 8'h00, 1'b1, 1'b0);
    send("R4 read again", 8'hA5, 1'b0, 1'b0);
    send("R4 relatch", 8'h05, 1'b1, 1'b0);
    pulse_clear();
    send("R8 fresh latch", 8'h04, 1'b1, 1'b0);
    send("R2 clear", 8'h00, 1'b0, 1'b0);
    send("R3 latch", 8'h06, 1'b1, 1'b0);
    send("R8 same cycle", 8'h00, 1'b1, 1'b1);
    send("R8 after clear", 8'h05, 1'b1, 1'b0);
    send("R4 read set", 8'h00, 1'b0, 1'b0);
    send("R5 probe", 8'h0B, 1'b1, 1'b0);
    send("R6 known zero", 8'h77, 1'b0, 1'b0);
    send("R5 sticky", 8'h0B, 1'b0, 1'b0);
    do_reset();

    for (int i = 0; i < 600; i++) begin
      r = int'($urandom % 10);
      case (r)
        0: b = 8'h04;
        1: b = 8'h05;
        2: b = 8'h06;
        3: b = 8'h0B;
        4: b = 8'h00;
        default: b = 8'($urandom);
      endcase
      h = ($urandom % 4) != 0;
      c = ($urandom % 16) == 0;
      send("R1-random", b, h, c);
      if (i == 300) do_reset();
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule